// File: doc/BRIEF.md
# Key-Protected Watchdog Timer

This block is a memory-mapped watchdog timer. An 8-bit counter counts up from a value that software preloads. Each step comes from a tick of a power-of-two prescaler that divides the input clock. If the counter wraps past 255, the block raises an overflow flag. When the block is in watchdog mode and reset is enabled, the wrap also drives a system-reset pulse of fixed length. Software keeps the system alive by reloading the counter before it wraps.

The block has three 16-bit write registers: control, counter and reset control. A write to any of them is refused unless its upper byte holds the key for that register. The overflow flag has a two-step clear. Software must first read the reset-control register while the flag is set, and only then does one exact clear value written to that register drop the flag. Reads return the selected register in an 8-bit data word.

Top module: `wdg_keyed`

## Requirements
- R1: After reset, the registers at offsets 0, 2 and 4 read 0x00 and `sys_rst_o` is low.
- R2: A write to offset 0 takes effect only with 0xA5 in bits 15:8. It then sets watchdog mode from bit 6, run from bit 5 and the clock select from bits CKS_W-1:0. The read-back shows these fields at the same bit positions, with every other bit 0. A write with any other key leaves the register unchanged.
- R3: A write to offset 2 with 0x5A in bits 15:8 loads bits 7:0 into the counter. Offset 2 reads the live count. A write with any other key leaves the count unchanged.
- R4: A write to offset 4 with 0x5A in bits 15:8 sets reset-enable from bit 6 and does not touch the flag. Offset 4 reads the flag in bit 7 and reset-enable in bit 6. A write to offset 4 with key 0xA5 never changes reset-enable.
- R5: While run is set, the counter steps once every 2^(BASE_SHIFT+select) input clocks. The first step comes that many clocks after the write edge that enables run. Every accepted write to offset 0 restarts the prescaler.
- R6: While run is clear, the counter holds its value.
- R7: A step taken at count 255 wraps the counter to 0 and sets the flag. Loading N therefore gives 256−N steps before the flag is set.
- R8: The exact write 0xA500 to offset 4 clears the flag only after a read of offset 4 made while the flag was set. Without such a read, or with a different low byte, the flag stays set.
- R9: A wrap with watchdog mode and reset-enable both set drives `sys_rst_o` high for exactly PULSE_LEN clocks, starting the cycle after the wrap. A wrap in interval mode (bit 6 clear) gives no pulse.
- R10: Reloading the counter at intervals shorter than its time to wrap keeps the flag clear and `sys_rst_o` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Input clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| addr_i | input | 3 | Byte offset of the register |
| wdata_i | input | 16 | Write data: key in the upper byte, value in the lower byte |
| we_i | input | 1 | Write strobe |
| re_i | input | 1 | Read strobe; arms the flag clear |
| rdata_o | output | 8 | Read data of the register at `addr_i` |
| sys_rst_o | output | 1 | System-reset request pulse |

## Verification
The bench places the first counter step and the restart on an exact clock edge. If the prescaler dropped its restart on a control write, the step would come early. If the divider were off by one, the count would be wrong at the edge the bench samples. It tries the clear value without a prior read, after a read, with a wrong low byte, and after a read made while the flag was still clear. A flag clear that accepted a stale or missing read would drop the flag where it must stay set. It measures the reset pulse edge to edge, checks that a wrap in interval mode gives no pulse, and checks that a wrong key to each register changes nothing. A design that let a mismatched key through would show the new value on read-back.

// File: rtl/wdg_keyed_pkg.sv
package wdg_keyed_pkg;
  localparam int unsigned ADDR_W = 3;

  localparam logic [ADDR_W-1:0] OFF_CTRL = 3'd0;
  localparam logic [ADDR_W-1:0] OFF_CNT  = 3'd2;
  localparam logic [ADDR_W-1:0] OFF_RCTL = 3'd4;

  localparam logic [7:0]  KEY_CTRL = 8'hA5;
  localparam logic [7:0]  KEY_CNT  = 8'h5A;
  localparam logic [7:0]  KEY_RCTL = 8'h5A;
  localparam logic [15:0] FLAG_CLR = 16'hA500;

  localparam int unsigned BIT_WD  = 6;
  localparam int unsigned BIT_RUN = 5;
  localparam int unsigned BIT_REN = 6;
  localparam int unsigned BIT_OVF = 7;

  typedef struct packed {
    logic wd;
    logic run;
  } ctrl_mode_t;
endpackage

// File: rtl/wdg_keyed_prescaler.sv
module wdg_keyed_prescaler #(
  parameter int unsigned CKS_W      = 3,
  parameter int unsigned BASE_SHIFT = 7
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             run_i,
  input  logic             restart_i,
  input  logic [CKS_W-1:0] sel_i,
  output logic             tick_o
);
  localparam int unsigned SEL_MAX = (1 << CKS_W) - 1;
  localparam int unsigned PRE_W   = BASE_SHIFT + SEL_MAX;

  logic [PRE_W-1:0] pre_q;
  logic [PRE_W-1:0] lim;
  int unsigned      sh;

  // Largest select shifts to PRE_W, so the 1 falls off and lim becomes all ones.
  always_comb begin
    sh  = BASE_SHIFT + int'(sel_i);
    lim = (PRE_W'(1) << sh) - PRE_W'(1);
  end

  assign tick_o = run_i && !restart_i && (pre_q == lim);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                  pre_q <= '0;
    else if (restart_i || !run_i) pre_q <= '0;
    else if (pre_q == lim)        pre_q <= '0;
    else                          pre_q <= pre_q + PRE_W'(1);
  end

  p_tick_gap_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_o && lim != '0) |=> !tick_o);
endmodule

// File: rtl/wdg_keyed_counter.sv
module wdg_keyed_counter #(
  parameter int unsigned CNT_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [CNT_W-1:0] load_val_i,
  input  logic             tick_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             wrap_o
);
  logic [CNT_W-1:0] cnt_q;

  // A load in the same cycle as a tick wins and suppresses the wrap.
  assign wrap_o = tick_i && !load_i && (cnt_q == '1);
  assign cnt_o  = cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (load_i) cnt_q <= load_val_i;
    else if (tick_i) cnt_q <= cnt_q + CNT_W'(1);
  end

  p_load_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |=> cnt_o == $past(load_val_i));
endmodule

// File: rtl/wdg_keyed_rst_pulse.sv
module wdg_keyed_rst_pulse #(
  parameter int unsigned PULSE_LEN = 16
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic trig_i,
  output logic rst_o
);
  localparam int unsigned PW = $clog2(PULSE_LEN + 1);

  logic [PW-1:0] left_q;

  assign rst_o = (left_q != '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     left_q <= '0;
    else if (trig_i) left_q <= PW'(PULSE_LEN);
    else if (rst_o)  left_q <= left_q - PW'(1);
  end

  p_start_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    trig_i |=> rst_o);
  p_idle_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!trig_i && !rst_o) |=> !rst_o);
endmodule

// File: rtl/wdg_keyed.sv
module wdg_keyed
  import wdg_keyed_pkg::*;
#(
  parameter int unsigned CKS_W      = 3,
  parameter int unsigned BASE_SHIFT = 7,
  parameter int unsigned PULSE_LEN  = 16
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic [2:0]  addr_i,
  input  logic [15:0] wdata_i,
  input  logic        we_i,
  input  logic        re_i,
  output logic [7:0]  rdata_o,
  output logic        sys_rst_o
);
  localparam int unsigned CNT_W = 8;
  localparam int unsigned PAD_W = BIT_RUN - CKS_W;

  ctrl_mode_t       mode_q;
  logic [CKS_W-1:0] sel_q;
  logic             ren_q;
  logic             ovf_q;
  logic             arm_q;

  logic [7:0]       key;
  logic             ctrl_wr, cnt_wr, ren_wr, clr_wr, arm_set;
  logic             tick, wrap, trig;
  logic [CNT_W-1:0] cnt;

  assign key     = wdata_i[15:8];
  assign ctrl_wr = we_i && (addr_i == OFF_CTRL) && (key == KEY_CTRL);
  assign cnt_wr  = we_i && (addr_i == OFF_CNT)  && (key == KEY_CNT);
  assign ren_wr  = we_i && (addr_i == OFF_RCTL) && (key == KEY_RCTL);
  assign clr_wr  = we_i && (addr_i == OFF_RCTL) && (wdata_i == FLAG_CLR);
  // Only a read that actually sees the flag set arms the clear.
  assign arm_set = re_i && (addr_i == OFF_RCTL) && ovf_q;
  assign trig    = wrap && mode_q.wd && ren_q;

  wdg_keyed_prescaler #(
    .CKS_W      (CKS_W),
    .BASE_SHIFT (BASE_SHIFT)
  ) u_pre (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .run_i     (mode_q.run),
    .restart_i (ctrl_wr),
    .sel_i     (sel_q),
    .tick_o    (tick)
  );

  wdg_keyed_counter #(
    .CNT_W (CNT_W)
  ) u_cnt (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .load_i     (cnt_wr),
    .load_val_i (wdata_i[CNT_W-1:0]),
    .tick_i     (tick),
    .cnt_o      (cnt),
    .wrap_o     (wrap)
  );

  wdg_keyed_rst_pulse #(
    .PULSE_LEN (PULSE_LEN)
  ) u_pulse (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .trig_i (trig),
    .rst_o  (sys_rst_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_q <= '0;
      sel_q  <= '0;
      ren_q  <= 1'b0;
      ovf_q  <= 1'b0;
      arm_q  <= 1'b0;
    end else begin
      if (ctrl_wr) begin
        mode_q.wd  <= wdata_i[BIT_WD];
        mode_q.run <= wdata_i[BIT_RUN];
        sel_q      <= wdata_i[CKS_W-1:0];
      end
      if (ren_wr) ren_q <= wdata_i[BIT_REN];
      if (wrap) begin
        ovf_q <= 1'b1;
      end else if (clr_wr && arm_q) begin
        ovf_q <= 1'b0;
        arm_q <= 1'b0;
      end else if (arm_set) begin
        arm_q <= 1'b1;
      end
    end
  end

  always_comb begin
    unique case (addr_i)
      OFF_CTRL: rdata_o = {1'b0, mode_q.wd, mode_q.run, {PAD_W{1'b0}}, sel_q};
      OFF_CNT:  rdata_o = cnt;
      OFF_RCTL: rdata_o = {ovf_q, ren_q, 6'b0};
      default:  rdata_o = 8'h00;
    endcase
  end

  p_badkey_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && addr_i == OFF_CTRL && wdata_i[15:8] != KEY_CTRL) |=> $stable({mode_q, sel_q}));
  p_hold_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!mode_q.run && !cnt_wr) |=> $stable(cnt));
  p_wrap_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wrap |=> (cnt == '0) && ovf_q);
  p_clr_armed_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(ovf_q) |-> $past(arm_q));
  p_pulse_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wrap && mode_q.wd && ren_q) |=> sys_rst_o);
endmodule

// File: tb/wdg_keyed_tb.sv
`timescale 1ns/100ps
module wdg_keyed_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [2:0]  addr = '0;
  logic [15:0] wdata = '0;
  logic        we = 1'b0;
  logic        re = 1'b0;
  logic [7:0]  rdata;
  logic        sys_rst;
  int          vectors = 0;
  int          errs = 0;
  bit          done = 0;

  always #2.5 clk = ~clk;

  wdg_keyed #(.CKS_W(3), .BASE_SHIFT(2), .PULSE_LEN(16)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .addr_i(addr), .wdata_i(wdata),
    .we_i(we), .re_i(re), .rdata_o(rdata), .sys_rst_o(sys_rst)
  );

  task automatic chk(input string tag, input logic [15:0] got, input logic [15:0] exp);
    vectors++;
    if (got !== exp) begin
      errs++;
      $display("FAIL %s got %h exp %h", tag, got, exp);
    end
  endtask

  // All tasks start and end at a falling edge.
  task automatic wr(input logic [2:0] a, input logic [15:0] d);
    addr = a; wdata = d; we = 1'b1;
    @(negedge clk);
    we = 1'b0; wdata = '0;
  endtask

  task automatic rd_arm(input logic [2:0] a);
    addr = a; re = 1'b1;
    @(negedge clk);
    re = 1'b0;
  endtask

  task automatic chk_reg(input string tag, input logic [2:0] a, input logic [7:0] exp);
    addr = a;
    #0.5;
    chk(tag, {8'h00, rdata}, {8'h00, exp});
  endtask

  task automatic t_reset();
    chk_reg("R1 ctrl", 3'd0, 8'h00);
    chk_reg("R1 cnt", 3'd2, 8'h00);
    chk_reg("R1 rctl", 3'd4, 8'h00);
    chk("R1 sys_rst", {15'd0, sys_rst}, 16'd0);
  endtask

  task automatic t_ctrl_keys();
    wr(3'd0, 16'h5A65);
    chk_reg("R2 bad key", 3'd0, 8'h00);
    wr(3'd0, 16'hA55F);
    chk_reg("R2 field mask", 3'd0, 8'h47);
    wr(3'd0, 16'hA500);
    chk_reg("R2 cleared", 3'd0, 8'h00);
  endtask

  task automatic t_cnt_keys();
    wr(3'd2, 16'hA533);
    chk_reg("R3 bad key", 3'd2, 8'h00);
    wr(3'd2, 16'h5A33);
    chk_reg("R3 load", 3'd2, 8'h33);
    wr(3'd2, 16'h5A00);
  endtask

  task automatic t_rctl();
    wr(3'd4, 16'h5AFF);
    chk_reg("R4 enable set", 3'd4, 8'h40);
    wr(3'd4, 16'hA540);
    chk_reg("R4 wrong key", 3'd4, 8'h40);
    wr(3'd4, 16'h5A00);
    chk_reg("R4 enable clr", 3'd4, 8'h00);
  endtask

  task automatic t_prescale();
    wr(3'd2, 16'h5A00);
    wr(3'd0, 16'hA520);
    repeat (3) @(negedge clk);
    chk_reg("R5 before first step", 3'd2, 8'h00);
    @(negedge clk);
    chk_reg("R5 first step", 3'd2, 8'h01);
    repeat (4) @(negedge clk);
    chk_reg("R5 second step", 3'd2, 8'h02);
    repeat (2) @(negedge clk);
    wr(3'd0, 16'hA520);
    repeat (3) @(negedge clk);
    chk_reg("R5 restart delays step", 3'd2, 8'h02);
    @(negedge clk);
    chk_reg("R5 step after restart", 3'd2, 8'h03);
    wr(3'd0, 16'hA500);
    wr(3'd2, 16'h5A10);
    wr(3'd0, 16'hA521);
    repeat (7) @(negedge clk);
    chk_reg("R5 sel1 before step", 3'd2, 8'h10);
    @(negedge clk);
    chk_reg("R5 sel1 step", 3'd2, 8'h11);
    wr(3'd0, 16'hA500);
  endtask

  task automatic t_stop();
    wr(3'd2, 16'h5A80);
    wr(3'd0, 16'hA520);
    repeat (10) @(negedge clk);
    chk_reg("R6 running", 3'd2, 8'h82);
    wr(3'd0, 16'hA500);
    repeat (60) @(negedge clk);
    chk_reg("R6 held", 3'd2, 8'h82);
  endtask

  task automatic t_overflow_rst();
    wr(3'd4, 16'h5A40);
    wr(3'd2, 16'h5AFE);
    wr(3'd0, 16'hA560);
    repeat (7) @(negedge clk);
    chk_reg("R7 at 255", 3'd2, 8'hFF);
    chk("R9 no early pulse", {15'd0, sys_rst}, 16'd0);
    @(negedge clk);
    chk_reg("R7 wrapped", 3'd2, 8'h00);
    chk_reg("R7 flag set", 3'd4, 8'hC0);
    chk("R9 pulse start", {15'd0, sys_rst}, 16'd1);
    repeat (15) @(negedge clk);
    chk("R9 pulse last", {15'd0, sys_rst}, 16'd1);
    @(negedge clk);
    chk("R9 pulse end", {15'd0, sys_rst}, 16'd0);
    wr(3'd0, 16'hA500);
  endtask

  task automatic t_flag_clear();
    bit seen;
    wr(3'd4, 16'hA500);
    chk_reg("R8 no read no clear", 3'd4, 8'hC0);
    rd_arm(3'd4);
    wr(3'd4, 16'hA501);
    chk_reg("R8 wrong value", 3'd4, 8'hC0);
    wr(3'd4, 16'hA500);
    chk_reg("R8 cleared", 3'd4, 8'h40);
    rd_arm(3'd4);
    wr(3'd2, 16'h5AFC);
    wr(3'd0, 16'hA520);
    seen = 0;
    for (int i = 0; i < 15; i++) begin
      @(negedge clk);
      if (sys_rst) seen = 1;
    end
    chk_reg("R7 flag after 3 of 4 steps", 3'd4, 8'h40);
    @(negedge clk);
    chk_reg("R7 flag after 256-N steps", 3'd4, 8'hC0);
    wr(3'd0, 16'hA500);
    wr(3'd4, 16'hA500);
    chk_reg("R8 stale read not armed", 3'd4, 8'hC0);
    for (int i = 0; i < 20; i++) begin
      @(negedge clk);
      if (sys_rst) seen = 1;
    end
    chk("R9 interval mode no pulse", {15'd0, seen}, 16'd0);
    rd_arm(3'd4);
    wr(3'd4, 16'hA500);
    chk_reg("R8 cleared again", 3'd4, 8'h40);
  endtask

  task automatic t_keepalive();
    bit seen;
    seen = 0;
    wr(3'd2, 16'h5AF0);
    wr(3'd0, 16'hA560);
    for (int k = 0; k < 5; k++) begin
      for (int i = 0; i < 40; i++) begin
        @(negedge clk);
        if (sys_rst) seen = 1;
      end
      wr(3'd2, 16'h5AF0);
    end
    chk("R10 no pulse", {15'd0, seen}, 16'd0);
    chk_reg("R10 flag clear", 3'd4, 8'h40);
    wr(3'd0, 16'hA500);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_ctrl_keys();
    t_cnt_keys();
    t_rctl();
    t_prescale();
    t_stop();
    t_overflow_rst();
    t_flag_clear();
    t_keepalive();
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errs);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errs++;
      $display("FAIL watchdog expired got hang exp finish");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errs);
      $finish;
    end
  end
endmodule